// File: doc/BRIEF.md
# E1 Frame Alignment Receiver

This block takes the serial bit stream of a 2.048 Mbit/s E1 line, one bit per clock, and finds the 256-bit frame structure by looking for the alignment word carried in timeslot 0. It keeps hunting until it has seen a valid sequence over three consecutive frames: alignment word, then the alternate-frame word, then the alignment word again. It then holds alignment until the alignment word has been corrupted three times in a row. After that it starts hunting again.

While aligned it drives the timing strobes other receivers need. These are a one-cycle frame reference, a window over the eight bits of timeslot 0, and a level that tells frames carrying the alignment word apart from the alternate frames. The last two feed an external CRC multiframe tracker. That tracker returns two level strobes that mark frames 13 and 15 of its multiframe. The block uses them to capture the international spare bit of those frames. The block also reports loss of alignment and the remote alarm bit sent by the far end.

Line bits are numbered 1 to 8 within timeslot 0, and bit 1 arrives first. An alignment frame carries `0011011` in bits 2 to 8. An alternate frame carries 1 in bit 2 and the remote alarm in bit 3.

Top module: `e1fa_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `loss_align` is 1 and `frm_sync`, `ts0_win`, `fas_frm`, `rem_alarm`, `spare_bits` and `spare_vld` are all 0.
- R2: Alignment is declared in three steps. First comes a frame whose timeslot 0 bits 2 to 8 are `0011011`. The next frame must have bit 2 = 1, and the frame after that must carry the alignment word again. `loss_align` falls in the cycle after bit 8 of the third frame is sampled, and stays high before that.
- R3: If the second frame of the sequence has bit 2 = 0, alignment is not declared and the hunt restarts. A clean alignment word in the following frame then starts a fresh three-frame sequence.
- R4: `frm_sync` pulses for one cycle, only while aligned, in the cycle after bit 1 of timeslot 0 is sampled. This gives exactly one pulse per 256 bits.
- R5: While aligned, `ts0_win` is high for the eight cycles in which bits 1 to 8 of timeslot 0 are the newest sampled bits. `fas_frm` is 1 throughout alignment frames and 0 throughout alternate frames. Its value changes in the same cycle as `frm_sync`.
- R6: While aligned, the third consecutive alignment word that differs from `0011011` raises `loss_align` in the cycle after its bit 8 is sampled.
- R7: A correct alignment word clears the error run. The sequence two bad words, one good word, two bad words keeps alignment.
- R8: While aligned, `rem_alarm` takes bit 3 of each alternate frame's timeslot 0, in the cycle after its bit 8 is sampled. It holds through alignment frames and reads 0 from the second cycle after alignment is lost.
- R9: In an aligned alternate frame, `mf13_stb` high loads bit 1 into `spare_bits[0]`. In such a frame, `mf15_stb` high loads bit 1 into `spare_bits[1]` and pulses `spare_vld` for one cycle. Both take effect in the cycle after bit 8 is sampled.
- R10: `mf13_stb` and `mf15_stb` have no effect during alignment frames or while alignment is lost. `spare_bits` keeps its value and `spare_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Decoded serial line data |
| mf13_stb | input | 1 | Level from the CRC tracker: current frame is multiframe frame 13 |
| mf15_stb | input | 1 | Level from the CRC tracker: current frame is multiframe frame 15 |
| frm_sync | output | 1 | One-cycle frame reference pulse |
| ts0_win | output | 1 | High during the timeslot 0 bits |
| fas_frm | output | 1 | 1 in frames carrying the alignment word |
| loss_align | output | 1 | 1 while frame alignment is not held |
| rem_alarm | output | 1 | Remote alarm bit from alternate frames |
| spare_bits | output | 2 | Captured spare bits: [0] frame 13, [1] frame 15 |
| spare_vld | output | 1 | One-cycle pulse when the frame 15 spare bit is loaded |

## Verification
Two updates land on the same clock edge: the remote alarm and the frame-15 spare capture. Both are taken at the end of timeslot 0 of an alternate frame. The bench sends an alternate frame with the frame 15 strobe high, bit 1 set and bit 3 set. One cycle after bit 8 it checks three results together: `rem_alarm` has changed, `spare_bits[1]` holds the new bit, and `spare_vld` is pulsing. Loss of alignment also shares its decision edge with alignment-word checking. The bench judges it by the cycle where `loss_align` rises, and checks that the remote alarm is cleared afterwards.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

    localparam int          FRAME_LEN  = 256;
    localparam int          SLOT_LEN   = 8;
    localparam int          MISS_LIMIT = 3;
    localparam logic [6:0]  SYNC_BODY  = 7'b0011011;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_WAIT_ALT,
        ST_WAIT_SYNC,
        ST_LOCKED
    } align_state_t;

    // newest eight bits, si = bit 1 (oldest), body[6] = bit 2 ... body[0] = bit 8
    typedef struct packed {
        logic       si;
        logic [6:0] body;
    } slot_word_t;

    function automatic logic is_sync_word(input slot_word_t w);
        return w.body == SYNC_BODY;
    endfunction

    function automatic logic alt_marker_ok(input slot_word_t w);
        return w.body[6];
    endfunction

    function automatic logic alt_alarm_bit(input slot_word_t w);
        return w.body[5];
    endfunction

endpackage

// File: rtl/e1fa_shift.sv
module e1fa_shift
    import e1fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    output slot_word_t word
);
    logic [7:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[6:0], rx_bit};
    end

    assign word = slot_word_t'(sr);
endmodule

// File: rtl/e1fa_timer.sv
module e1fa_timer #(
    parameter int FRAME_BITS = 256,
    parameter int TS_BITS    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic frame_top,
    output logic in_slot0,
    output logic slot0_end,
    output logic sync_frame
);
    localparam int POS_W = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] END_POS  = POS_W'(TS_BITS - 1);
    localparam logic [POS_W-1:0] LOAD_POS = POS_W'(TS_BITS);

    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= '0;
            sync_frame <= 1'b0;
        end else if (load) begin
            pos        <= LOAD_POS;
            sync_frame <= 1'b1;
        end else begin
            if (pos == LAST_POS) begin
                pos        <= '0;
                sync_frame <= ~sync_frame;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    assign frame_top = (pos == '0);
    assign in_slot0  = (pos <= END_POS);
    assign slot0_end = (pos == END_POS);
endmodule

// File: rtl/e1fa_align.sv
module e1fa_align
    import e1fa_pkg::*;
#(
    parameter int LOSS_LIMIT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  slot_word_t   word,
    input  logic         slot0_end,
    input  logic         sync_frame,
    output logic         load,
    output align_state_t state
);
    localparam int ERR_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_LIMIT - 1);

    logic [ERR_W-1:0] miss_run;
    logic             hit;

    assign hit  = is_sync_word(word);
    assign load = (state == ST_HUNT) && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            miss_run <= '0;
        end else begin
            case (state)
                ST_HUNT: begin
                    miss_run <= '0;
                    if (hit) state <= ST_WAIT_ALT;
                end
                ST_WAIT_ALT: if (slot0_end) begin
                    state <= (!sync_frame && alt_marker_ok(word)) ? ST_WAIT_SYNC : ST_HUNT;
                end
                ST_WAIT_SYNC: if (slot0_end) begin
                    state <= (sync_frame && hit) ? ST_LOCKED : ST_HUNT;
                end
                ST_LOCKED: if (slot0_end && sync_frame) begin
                    if (hit) begin
                        miss_run <= '0;
                    end else if (miss_run == ERR_LAST) begin
                        miss_run <= '0;
                        state    <= ST_HUNT;
                    end else begin
                        miss_run <= miss_run + 1'b1;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/e1fa_extract.sv
module e1fa_extract
    import e1fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       locked,
    input  logic       slot0_end,
    input  logic       sync_frame,
    input  slot_word_t word,
    input  logic       mf13_stb,
    input  logic       mf15_stb,
    output logic       rem_alarm,
    output logic [1:0] spare_bits,
    output logic       spare_vld
);
    logic alt_point;
    assign alt_point = locked && slot0_end && !sync_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_alarm  <= 1'b0;
            spare_bits <= '0;
            spare_vld  <= 1'b0;
        end else begin
            spare_vld <= 1'b0;
            if (!locked) begin
                rem_alarm <= 1'b0;
            end else if (alt_point) begin
                rem_alarm <= alt_alarm_bit(word);
                if (mf13_stb) spare_bits[0] <= word.si;
                if (mf15_stb) begin
                    spare_bits[1] <= word.si;
                    spare_vld     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/e1fa_rx.sv
module e1fa_rx
    import e1fa_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_LEN,
    parameter int TS_BITS    = SLOT_LEN,
    parameter int LOSS_LIMIT = MISS_LIMIT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       mf13_stb,
    input  logic       mf15_stb,
    output logic       frm_sync,
    output logic       ts0_win,
    output logic       fas_frm,
    output logic       loss_align,
    output logic       rem_alarm,
    output logic [1:0] spare_bits,
    output logic       spare_vld
);
    slot_word_t   word;
    align_state_t state;
    logic         load, frame_top, in_slot0, slot0_end, sync_frame, locked;

    e1fa_shift u_shift (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .word(word)
    );

    e1fa_timer #(.FRAME_BITS(FRAME_BITS), .TS_BITS(TS_BITS)) u_timer (
        .clk(clk), .rst(rst), .load(load), .frame_top(frame_top),
        .in_slot0(in_slot0), .slot0_end(slot0_end), .sync_frame(sync_frame)
    );

    e1fa_align #(.LOSS_LIMIT(LOSS_LIMIT)) u_align (
        .clk(clk), .rst(rst), .word(word), .slot0_end(slot0_end),
        .sync_frame(sync_frame), .load(load), .state(state)
    );

    assign locked = (state == ST_LOCKED);

    e1fa_extract u_extract (
        .clk(clk), .rst(rst), .locked(locked), .slot0_end(slot0_end),
        .sync_frame(sync_frame), .word(word), .mf13_stb(mf13_stb),
        .mf15_stb(mf15_stb), .rem_alarm(rem_alarm),
        .spare_bits(spare_bits), .spare_vld(spare_vld)
    );

    assign loss_align = !locked;
    assign frm_sync   = locked && frame_top;
    assign ts0_win    = locked && in_slot0;
    assign fas_frm    = locked && sync_frame;
endmodule

// File: rtl/e1fa_rx_chk.sv
module e1fa_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       frm_sync,
    input logic       ts0_win,
    input logic       fas_frm,
    input logic       loss_align,
    input logic       rem_alarm,
    input logic [1:0] spare_bits,
    input logic       spare_vld
);
    a_r4_sync_single: assert property (@(posedge clk) disable iff (rst)
        frm_sync |=> !frm_sync);

    a_r4_sync_aligned: assert property (@(posedge clk) disable iff (rst)
        frm_sync |-> (!loss_align && ts0_win));

    a_r5_window_starts_at_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(ts0_win) |-> frm_sync);

    a_r2_lock_after_slot0: assert property (@(posedge clk) disable iff (rst)
        $fell(loss_align) |-> ($past(ts0_win) == 1'b0 && fas_frm && !ts0_win));

    a_r8_alarm_cleared: assert property (@(posedge clk) disable iff (rst)
        loss_align |=> !rem_alarm);

    a_r9_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        spare_vld |=> !spare_vld);

    a_r10_spare_only_aligned: assert property (@(posedge clk) disable iff (rst)
        !$stable(spare_bits) |-> $past(!loss_align));
endmodule

bind e1fa_rx e1fa_rx_chk u_chk (
    .clk(clk), .rst(rst), .frm_sync(frm_sync), .ts0_win(ts0_win),
    .fas_frm(fas_frm), .loss_align(loss_align), .rem_alarm(rem_alarm),
    .spare_bits(spare_bits), .spare_vld(spare_vld)
);

// File: tb/tb_e1fa_rx.sv
module tb_e1fa_rx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       mf13_stb = 1'b0;
    logic       mf15_stb = 1'b0;
    logic       frm_sync, ts0_win, fas_frm, loss_align, rem_alarm, spare_vld;
    logic [1:0] spare_bits;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic s_sync1, s_win1, s_win9, s_vld, s_loa, s_rai, s_fas;
    logic [1:0] s_spare;
    int n_sync;

    e1fa_rx dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .mf13_stb(mf13_stb),
        .mf15_stb(mf15_stb), .frm_sync(frm_sync), .ts0_win(ts0_win),
        .fas_frm(fas_frm), .loss_align(loss_align), .rem_alarm(rem_alarm),
        .spare_bits(spare_bits), .spare_vld(spare_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // alignment frame when sync=1, alternate frame otherwise
    task automatic send_frame(input bit sync, input bit si, input bit a, input bit corrupt);
        logic [7:0] ts;
        ts[0] = si;
        if (sync) begin
            ts[1] = 0; ts[2] = 0; ts[3] = 1; ts[4] = 1; ts[5] = 0; ts[6] = 1;
            ts[7] = corrupt ? 1'b0 : 1'b1;
        end else begin
            ts[1] = ~corrupt; ts[2] = a;
            ts[3] = 1; ts[4] = 1; ts[5] = 1; ts[6] = 1; ts[7] = 1;
        end
        n_sync = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (frm_sync) n_sync++;
            if (i == 1) begin s_sync1 = frm_sync; s_win1 = ts0_win; end
            if (i == 9) begin s_vld = spare_vld; s_win9 = ts0_win; end
            if (i == 10) begin
                s_loa = loss_align; s_rai = rem_alarm;
                s_fas = fas_frm;    s_spare = spare_bits;
            end
            rx_bit = (i < 8) ? ts[i] : 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; rx_bit = 1'b0; mf13_stb = 1'b0; mf15_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 loss_align", int'(loss_align), 1);
        chk("R1 frm_sync", int'(frm_sync), 0);
        chk("R1 ts0_win", int'(ts0_win), 0);
        chk("R1 fas_frm", int'(fas_frm), 0);
        chk("R1 rem_alarm", int'(rem_alarm), 0);
        chk("R1 spare_bits", int'(spare_bits), 0);
        chk("R1 spare_vld", int'(spare_vld), 0);
    endtask

    task automatic t_align();
        send_frame(1, 0, 0, 0);
        chk("R2 first frame loss", int'(s_loa), 1);
        send_frame(0, 0, 0, 0);
        chk("R2 second frame loss", int'(s_loa), 1);
        send_frame(1, 0, 0, 0);
        chk("R2 locked after third", int'(s_loa), 0);
        send_frame(0, 0, 0, 0);
        chk("R4 sync at bit1", int'(s_sync1), 1);
        chk("R4 one pulse per frame", n_sync, 1);
        chk("R5 window at bit1", int'(s_win1), 1);
        chk("R5 window closed after bit8", int'(s_win9), 0);
        chk("R5 alternate frame flag", int'(s_fas), 0);
        send_frame(1, 0, 0, 0);
        chk("R5 alignment frame flag", int'(s_fas), 1);
        chk("R4 pulse count", n_sync, 1);
    endtask

    task automatic t_alarm();
        send_frame(0, 0, 1, 0);
        chk("R8 alarm set", int'(s_rai), 1);
        send_frame(1, 0, 0, 0);
        chk("R8 alarm held in alignment frame", int'(s_rai), 1);
        send_frame(0, 0, 0, 0);
        chk("R8 alarm cleared", int'(s_rai), 0);
    endtask

    task automatic t_spare();
        send_frame(1, 0, 0, 0);
        mf15_stb = 1'b1;
        send_frame(0, 1, 1, 0);
        mf15_stb = 1'b0;
        chk("R9 frame15 vld", int'(s_vld), 1);
        chk("R9 frame15 bit", int'(s_spare), 2);
        chk("R8 alarm same edge as capture", int'(s_rai), 1);
        mf13_stb = 1'b1;
        send_frame(1, 1, 0, 0);
        chk("R10 strobe ignored in alignment frame", int'(s_spare), 2);
        send_frame(0, 1, 1, 0);
        mf13_stb = 1'b0;
        chk("R9 frame13 bit", int'(s_spare), 3);
        chk("R9 no vld for frame13", int'(s_vld), 0);
        mf15_stb = 1'b1;
        send_frame(1, 0, 0, 0);
        mf15_stb = 1'b0;
        chk("R10 frame15 strobe ignored in alignment frame", int'(s_spare), 3);
        chk("R10 no vld in alignment frame", int'(s_vld), 0);
    endtask

    task automatic t_loss();
        send_frame(0, 0, 1, 0);
        send_frame(1, 0, 0, 1);
        send_frame(0, 0, 1, 0);
        send_frame(1, 0, 0, 1);
        send_frame(0, 0, 1, 0);
        send_frame(1, 0, 0, 0);
        send_frame(0, 0, 1, 0);
        send_frame(1, 0, 0, 1);
        send_frame(0, 0, 1, 0);
        send_frame(1, 0, 0, 1);
        chk("R7 run cleared by good word", int'(s_loa), 0);
        send_frame(0, 0, 1, 0);
        chk("R8 alarm before loss", int'(s_rai), 1);
        send_frame(1, 0, 0, 1);
        chk("R6 loss after third bad word", int'(s_loa), 1);
        mf15_stb = 1'b1;
        send_frame(0, 0, 1, 0);
        mf15_stb = 1'b0;
        chk("R8 alarm zero when unaligned", int'(s_rai), 0);
        chk("R4 no pulse when unaligned", n_sync, 0);
        chk("R10 spare held when unaligned", int'(s_spare), 3);
        chk("R10 no vld when unaligned", int'(s_vld), 0);
        send_frame(1, 0, 0, 0);
        send_frame(0, 0, 0, 0);
        send_frame(1, 0, 0, 0);
        chk("R6 hunt restarts and relocks", int'(s_loa), 0);
    endtask

    task automatic t_abort();
        do_reset();
        send_frame(1, 0, 0, 0);
        send_frame(0, 0, 0, 1);
        send_frame(1, 0, 0, 0);
        chk("R3 no lock after bad alternate", int'(s_loa), 1);
        send_frame(0, 0, 0, 0);
        chk("R3 still hunting", int'(s_loa), 1);
        send_frame(1, 0, 0, 0);
        chk("R3 fresh sequence locks", int'(s_loa), 0);
    endtask

    initial begin
        t_reset();
        t_align();
        t_alarm();
        t_spare();
        t_loss();
        t_abort();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule